// File: doc/BRIEF.md
# Tag-Indexed Measurement Dispatcher

This block sits between a merged sample input and up to four downstream stream processors. Several sources (frame synchronizers, a time port, an analog-to-digital port) share one word-wide input. Each sample is a pair of 32-bit words, an identifier word followed by a data word. The pair is queued, and the dispatcher then works out where it goes through two reads of a local word memory. The tag in the identifier selects a vector word in the lower half of the memory. The vector gives the offset of a processing-table entry in the upper half. That entry's first word, the header, names the target processor and the number of instruction words that follow it.

The dispatcher then sends, over one shared 32-bit distribution bus with valid/ready handshaking, the identifier, the data, the header and the instruction words that follow the header. A header also carries an algorithm code and a destination code, which are forwarded without being decoded. The host fills the memory through a write port and sets the mode: free running, or single step, where each step pulse releases exactly one sample.

Top module: `tag_dispatch`

## Requirements
- R1: Of each pair pushed on the input, the first word is the identifier and the second is the data. Identifier bits [7:0] are the tag, and the identifier is forwarded bit for bit, including its time, status and stream bits.
- R2: The vector is the memory word at address tag (lower half). Only vector bits [7:0] are used, as the header offset; the header is the word at address 256 + offset, and vector bits [31:8] have no effect.
- R3: The input queue holds 8 words. `in_full` is high exactly while 8 words are held, and a word pushed while `in_full` is high is dropped.
- R4: A transfer carries, in this order: the identifier, the data, the header, then N table words, where N is header bits [11:8] (0 to 15). Table word k (k = 1..N) is read at upper-half offset (offset + k) modulo 256.
- R5: `dbus_sel` equals header bits [1:0] for the whole transfer. A word is taken only in a cycle where `dbus_valid` and `dbus_ready[dbus_sel]` are both high, and ready bits of the other processors have no effect.
- R6: `dbus_last` is high on the final word of a transfer and on no other word.
- R7: While `dbus_valid` is high and the word is not taken, the word, `dbus_sel` and `dbus_last` are held unchanged into the next cycle.
- R8: Transfers are atomic: after the final word is taken, `dbus_valid` is low in the next cycle, and no word of another sample appears inside a transfer.
- R9: With `run_en` high, queued pairs are dispatched in arrival order without any step pulse.
- R10: With `run_en` low, no pair starts unless a step is pending. A `step` pulse sets the pending request, and starting a pair clears it. Pulses that arrive while a request is pending, or in the cycle it is taken, are absorbed.
- R11: After reset, the queue is empty (`in_full` low) and `dbus_valid` is low.
- R12: A cycle with `cfg_we` high writes `cfg_wdata` to memory address `cfg_addr`, and later lookups use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_push | input | 1 | Input word strobe |
| in_word | input | 32 | Input word (identifier, then data) |
| in_full | output | 1 | Queue full; sources must hold their words |
| run_en | input | 1 | 1 = free run, 0 = single step |
| step | input | 1 | Step request pulse |
| cfg_we | input | 1 | Memory write enable |
| cfg_addr | input | 9 | Memory write address (lower half vectors, upper half tables) |
| cfg_wdata | input | 32 | Memory write data |
| dbus_ready | input | 4 | Per-processor ready |
| dbus_valid | output | 1 | Distribution bus word valid |
| dbus_sel | output | 2 | Target processor index |
| dbus_word | output | 32 | Distribution bus word |
| dbus_last | output | 1 | Final word of a transfer |

## Verification
The hold and gap properties assume that the host writes no memory word that a transfer in flight reads, since a table word is read live while it is being offered. The stimulus therefore loads the whole memory before the first sample is pushed and writes nothing afterwards. The full-flag property assumes that sources push only through `in_push`. The bench changes the ready bits only between clock edges, following a fixed pattern (all ready, alternating, or only the processors not selected), so that every stall is a clean hold.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

    // Header word layout used by the controller
    localparam int CNT_LSB = 8;
    localparam int CNT_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_SEND = 2'd2
    } disp_state_e;

endpackage

// File: rtl/tdisp_queue.sv
module tdisp_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop_pair,
    output logic         full,
    output logic         pair_ready,
    output logic [W-1:0] head_first,
    output logic [W-1:0] head_second
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t      q_q, q_d;
    logic [W-1:0]  store [DEPTH];
    logic          push_ok;
    logic [AW-1:0] rd_nxt;

    always_comb begin
        push_ok = push && (q_q.cnt != CW'(DEPTH));
        rd_nxt  = q_q.rd + AW'(1);
        q_d     = q_q;
        if (push_ok) begin
            q_d.wr = q_q.wr + AW'(1);
        end
        if (pop_pair) begin
            q_d.rd = q_q.rd + AW'(2);
        end
        q_d.cnt = q_q.cnt + (push_ok ? CW'(1) : CW'(0)) - (pop_pair ? CW'(2) : CW'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[q_q.wr] <= push_word;
        end
    end

    assign full        = (q_q.cnt == CW'(DEPTH));
    assign pair_ready  = (q_q.cnt >= CW'(2));
    assign head_first  = store[q_q.rd];
    assign head_second = store[rd_nxt];

endmodule

// File: rtl/tdisp_mem.sv
module tdisp_mem #(
    parameter int AW = 9,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr_a,
    output logic [W-1:0]  rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_data_b
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data_a = cells[rd_addr_a];
    assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/tdisp_ctrl.sv
module tdisp_ctrl
    import tdisp_pkg::*;
#(
    parameter int MEM_AW = 9,
    parameter int N_PROC = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              step,
    input  logic              pair_ready,
    input  logic [31:0]       head_first,
    input  logic [31:0]       head_second,
    output logic              pop_pair,
    output logic [MEM_AW-1:0] mem_addr_a,
    input  logic [31:0]       mem_data_a,
    output logic [MEM_AW-1:0] mem_addr_b,
    input  logic [31:0]       mem_data_b,
    input  logic [N_PROC-1:0] dbus_ready,
    output logic              dbus_valid,
    output logic [SEL_W-1:0]  dbus_sel,
    output logic [31:0]       dbus_word,
    output logic              dbus_last
);
    localparam int OFF_W = MEM_AW - 1;
    localparam int IDX_W = CNT_W + 1;

    typedef struct packed {
        disp_state_e      state;
        logic [31:0]      id;
        logic [31:0]      data;
        logic [31:0]      hdr;
        logic [OFF_W-1:0] base;
        logic [IDX_W-1:0] idx;
        logic             step_pend;
    } ctrl_state_t;

    ctrl_state_t      r_q, r_d;
    logic [CNT_W-1:0] words_after;
    logic [OFF_W-1:0] tbl_off;
    logic             start;
    logic             taken;

    always_comb begin
        r_d         = r_q;
        pop_pair    = 1'b0;
        dbus_valid  = 1'b0;
        dbus_word   = '0;
        dbus_last   = 1'b0;
        dbus_sel    = r_q.hdr[SEL_W-1:0];
        words_after = r_q.hdr[CNT_LSB +: CNT_W];
        tbl_off     = r_q.base + OFF_W'(r_q.idx) - OFF_W'(2);
        mem_addr_a  = (r_q.state == ST_SEND) ? {1'b1, tbl_off}
                                             : {1'b0, r_q.id[OFF_W-1:0]};
        mem_addr_b  = {1'b1, mem_data_a[OFF_W-1:0]};
        start       = (r_q.state == ST_IDLE) && pair_ready && (run_en || r_q.step_pend);
        taken       = dbus_ready[dbus_sel];

        if (run_en || start) begin
            r_d.step_pend = 1'b0;
        end else begin
            r_d.step_pend = r_q.step_pend | step;
        end

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    pop_pair  = 1'b1;
                    r_d.id    = head_first;
                    r_d.data  = head_second;
                    r_d.state = ST_LOOK;
                end
            end
            ST_LOOK: begin
                r_d.hdr   = mem_data_b;
                r_d.base  = mem_data_a[OFF_W-1:0];
                r_d.idx   = '0;
                r_d.state = ST_SEND;
            end
            ST_SEND: begin
                dbus_valid = 1'b1;
                dbus_last  = (r_q.idx == IDX_W'(words_after) + IDX_W'(2));
                case (r_q.idx)
                    IDX_W'(0): dbus_word = r_q.id;
                    IDX_W'(1): dbus_word = r_q.data;
                    IDX_W'(2): dbus_word = r_q.hdr;
                    default:   dbus_word = mem_data_a;
                endcase
                if (taken) begin
                    if (dbus_last) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/tag_dispatch.sv
module tag_dispatch #(
    parameter int Q_DEPTH = 8,
    parameter int MEM_AW  = 9,
    parameter int N_PROC  = 4,
    parameter int SEL_W   = $clog2(N_PROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_push,
    input  logic [31:0]       in_word,
    output logic              in_full,
    input  logic              run_en,
    input  logic              step,
    input  logic              cfg_we,
    input  logic [MEM_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [N_PROC-1:0] dbus_ready,
    output logic              dbus_valid,
    output logic [SEL_W-1:0]  dbus_sel,
    output logic [31:0]       dbus_word,
    output logic              dbus_last
);
    logic              pop_pair;
    logic              pair_ready;
    logic [31:0]       head_first;
    logic [31:0]       head_second;
    logic [MEM_AW-1:0] addr_a;
    logic [MEM_AW-1:0] addr_b;
    logic [31:0]       data_a;
    logic [31:0]       data_b;

    tdisp_queue #(.DEPTH(Q_DEPTH), .W(32)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (in_push),
        .push_word   (in_word),
        .pop_pair    (pop_pair),
        .full        (in_full),
        .pair_ready  (pair_ready),
        .head_first  (head_first),
        .head_second (head_second)
    );

    tdisp_mem #(.AW(MEM_AW), .W(32)) u_mem (
        .clk       (clk),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .rd_addr_a (addr_a),
        .rd_data_a (data_a),
        .rd_addr_b (addr_b),
        .rd_data_b (data_b)
    );

    tdisp_ctrl #(.MEM_AW(MEM_AW), .N_PROC(N_PROC), .SEL_W(SEL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .step        (step),
        .pair_ready  (pair_ready),
        .head_first  (head_first),
        .head_second (head_second),
        .pop_pair    (pop_pair),
        .mem_addr_a  (addr_a),
        .mem_data_a  (data_a),
        .mem_addr_b  (addr_b),
        .mem_data_b  (data_b),
        .dbus_ready  (dbus_ready),
        .dbus_valid  (dbus_valid),
        .dbus_sel    (dbus_sel),
        .dbus_word   (dbus_word),
        .dbus_last   (dbus_last)
    );

endmodule

// File: rtl/tdisp_chk.sv
module tdisp_chk #(
    parameter int N_PROC = 4,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_push,
    input logic              in_full,
    input logic [N_PROC-1:0] dbus_ready,
    input logic              dbus_valid,
    input logic [SEL_W-1:0]  dbus_sel,
    input logic [31:0]       dbus_word,
    input logic              dbus_last
);
    logic took;
    assign took = dbus_valid && dbus_ready[dbus_sel];

    // R7: an offered word that is not taken stays put
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_valid && !took) |=> (dbus_valid && $stable(dbus_word)
                                   && $stable(dbus_sel) && $stable(dbus_last)))
        else $error("p_hold_r7");

    // R8: the bus goes quiet after the final word is taken
    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (took && dbus_last) |=> !dbus_valid)
        else $error("p_gap_r8");

    // R5: target stays the same inside a transfer
    p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !dbus_last) |=> (dbus_valid && $stable(dbus_sel)))
        else $error("p_sel_r5");

    // R3: the queue only becomes full through a push
    p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> $past(in_push))
        else $error("p_full_r3");

endmodule

bind tag_dispatch tdisp_chk #(.N_PROC(N_PROC), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_push    (in_push),
    .in_full    (in_full),
    .dbus_ready (dbus_ready),
    .dbus_valid (dbus_valid),
    .dbus_sel   (dbus_sel),
    .dbus_word  (dbus_word),
    .dbus_last  (dbus_last)
);

// File: tb/tag_dispatch_tb.sv
module tag_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_push = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_full;
    logic        run_en = 1'b0;
    logic        step = 1'b0;
    logic        cfg_we = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  dbus_ready = 4'hF;
    logic        dbus_valid;
    logic [1:0]  dbus_sel;
    logic [31:0] dbus_word;
    logic        dbus_last;

    int n_chk = 0;
    int n_bad = 0;
    int rdy_mode = 0;
    bit tgl = 1'b0;

    logic [31:0] sh_vec [256];
    logic [31:0] sh_tbl [256];

    always #4 clk = ~clk;

    tag_dispatch u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_push    (in_push),
        .in_word    (in_word),
        .in_full    (in_full),
        .run_en     (run_en),
        .step       (step),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .dbus_ready (dbus_ready),
        .dbus_valid (dbus_valid),
        .dbus_sel   (dbus_sel),
        .dbus_word  (dbus_word),
        .dbus_last  (dbus_last)
    );

    always @(negedge clk) begin
        tgl = ~tgl;
        case (rdy_mode)
            0:       dbus_ready = 4'hF;
            1:       dbus_ready = tgl ? 4'hF : 4'h0;
            default: dbus_ready = 4'b1110;
        endcase
    end

    task automatic chk(input bit c, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        in_push = 1'b1; in_word = w;
        @(negedge clk);
        in_push = 1'b0;
    endtask

    task automatic grab(output logic [31:0] w, output logic [1:0] s, output logic l, output bit ok);
        ok = 1'b0; w = '0; s = '0; l = 1'b0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk); #1;
            if (dbus_valid && dbus_ready[dbus_sel]) begin
                w = dbus_word; s = dbus_sel; l = dbus_last; ok = 1'b1;
                return;
            end
        end
    endtask

    // Collects one whole transfer and checks it against the shadow tables
    task automatic run_dispatch(input logic [31:0] id, input logic [31:0] data, input string rq);
        logic [7:0]  off;
        logic [31:0] hdr;
        logic [31:0] exp;
        logic [31:0] w;
        logic [1:0]  s;
        logic        l;
        bit          ok;
        int          n;
        off = sh_vec[id[7:0]][7:0];
        hdr = sh_tbl[off];
        n   = int'(hdr[11:8]);
        for (int k = 0; k < n + 3; k++) begin
            if (k == 0)      exp = id;
            else if (k == 1) exp = data;
            else if (k == 2) exp = hdr;
            else             exp = sh_tbl[8'(int'(off) + k - 2)];
            grab(w, s, l, ok);
            if (!ok) begin
                chk(1'b0, {rq, " timeout waiting for word"}, 32'(k), exp);
                return;
            end
            if (k == 0)      chk(w == exp, "R1 identifier word", w, exp);
            else if (k == 1) chk(w == exp, "R1 data word", w, exp);
            else if (k == 2) chk(w == exp, "R2 header word", w, exp);
            else             chk(w == exp, rq, w, exp);
            chk(s == hdr[1:0], "R5 sel", 32'(s), 32'(hdr[1:0]));
            chk(l == (k == n + 2), "R6 last", 32'(l), 32'(k == n + 2));
        end
        @(negedge clk); #1;
        chk(!dbus_valid, "R8 gap after last", 32'(dbus_valid), 32'd0);
    endtask

    task automatic quiet(input int cycles, input string rq);
        bit seen = 1'b0;
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk); #1;
            if (dbus_valid) seen = 1'b1;
        end
        chk(!seen, rq, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        #1;
        chk(!dbus_valid, "R11 valid after reset", 32'(dbus_valid), 32'd0);
        chk(!in_full, "R11 full after reset", 32'(in_full), 32'd0);
        run_en = 1'b1;
        quiet(8, "R11 empty queue sends nothing");
    endtask

    task automatic t_load;
        for (int i = 0; i < 256; i++) begin
            sh_tbl[i] = 32'hA500_0000 | 32'(i);
            wr(9'(256 + i), sh_tbl[i]);
        end
        sh_tbl[8'h10] = 32'h0000_5232; wr(9'h110, sh_tbl[8'h10]);
        sh_tbl[8'h40] = 32'h0000_0011; wr(9'h140, sh_tbl[8'h40]);
        sh_tbl[8'hF8] = 32'h0000_7F73; wr(9'h1F8, sh_tbl[8'hF8]);
        sh_tbl[8'h80] = 32'h0000_0100; wr(9'h180, sh_tbl[8'h80]);
        sh_vec[8'h11] = 32'hBEEF_0010; wr(9'h011, sh_vec[8'h11]);
        sh_vec[8'h22] = 32'hBEEF_0040; wr(9'h022, sh_vec[8'h22]);
        sh_vec[8'h33] = 32'h1234_00F8; wr(9'h033, sh_vec[8'h33]);
        sh_vec[8'h44] = 32'hBEEF_0080; wr(9'h044, sh_vec[8'h44]);
    endtask

    task automatic t_route;
        rdy_mode = 0; run_en = 1'b1;
        push_word(32'h5A3C_0011); push_word(32'h0000_1111);
        run_dispatch(32'h5A3C_0011, 32'h0000_1111, "R4 R9 R12 table word");
    endtask

    task automatic t_zero_count;
        rdy_mode = 0; run_en = 1'b1;
        push_word(32'hC1F2_0022); push_word(32'h2222_2222);
        run_dispatch(32'hC1F2_0022, 32'h2222_2222, "R4 zero count");
    endtask

    task automatic t_wrap_max;
        rdy_mode = 1; run_en = 1'b1;
        push_word(32'h0123_4533); push_word(32'h3333_3333);
        run_dispatch(32'h0123_4533, 32'h3333_3333, "R4 R7 wrap max count");
        rdy_mode = 0;
    endtask

    task automatic t_wrong_ready;
        rdy_mode = 2; run_en = 1'b1;
        push_word(32'h7700_0044); push_word(32'h4444_4444);
        repeat (10) @(negedge clk);
        #1;
        chk(dbus_valid, "R5 stalled offer valid", 32'(dbus_valid), 32'd1);
        chk(dbus_sel == 2'd0, "R5 stalled sel", 32'(dbus_sel), 32'd0);
        chk(dbus_word == 32'h7700_0044, "R5 other ready ignored", dbus_word, 32'h7700_0044);
        rdy_mode = 0;
        run_dispatch(32'h7700_0044, 32'h4444_4444, "R5 after release");
    endtask

    task automatic t_full;
        rdy_mode = 0; run_en = 1'b0;
        push_word(32'h1000_0011); push_word(32'hD000_0001);
        push_word(32'h2000_0022); push_word(32'hD000_0002);
        push_word(32'h3000_0044); push_word(32'hD000_0003);
        push_word(32'h4000_0011); push_word(32'hD000_0004);
        #1;
        chk(in_full, "R3 full at 8 words", 32'(in_full), 32'd1);
        push_word(32'hBAD0_0022);
        #1;
        chk(in_full, "R3 still full", 32'(in_full), 32'd1);
        run_en = 1'b1;
        run_dispatch(32'h1000_0011, 32'hD000_0001, "R9 order 1");
        run_dispatch(32'h2000_0022, 32'hD000_0002, "R9 order 2");
        run_dispatch(32'h3000_0044, 32'hD000_0003, "R9 order 3");
        run_dispatch(32'h4000_0011, 32'hD000_0004, "R9 order 4");
        quiet(10, "R3 dropped word not queued");
        push_word(32'h5000_0044); push_word(32'hD000_0005);
        run_dispatch(32'h5000_0044, 32'hD000_0005, "R3 next pair after drop");
    endtask

    task automatic t_step;
        rdy_mode = 0; run_en = 1'b0;
        push_word(32'h6100_0022); push_word(32'hE000_0001);
        push_word(32'h6200_0044); push_word(32'hE000_0002);
        quiet(15, "R10 no step no dispatch");
        @(negedge clk); step = 1'b1;
        @(negedge clk);
        @(negedge clk); step = 1'b0;
        run_dispatch(32'h6100_0022, 32'hE000_0001, "R10 first step");
        quiet(15, "R10 merged pulses give one dispatch");
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        run_dispatch(32'h6200_0044, 32'hE000_0002, "R10 second step");
        quiet(10, "R10 idle after step");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_en = 1'b0;
        t_load();
        t_route();
        t_zero_count();
        t_wrap_max();
        t_wrong_ready();
        t_full();
        t_step();
        summary();
        $finish;
    end

endmodule